// File: doc/BRIEF.md
# PRBS Timeslot Analyzer

This block checks a pseudo-random test pattern carried inside a 32-timeslot framed serial stream. A frame has 256 bit periods: slot n takes the eight bit periods that start 8n bit clocks after the frame-sync pulse. A 6-bit slot code picks which slots carry the pattern. Bits from the chosen slots go into a local shift-register sequence. Bits from all other slots are dropped.

The analyzer loads the received bits into its history register until its predictions hold for 32 selected bits in a row. It then raises the recovered flag and free-runs. From then on every selected bit that differs from the prediction adds one to a 14-bit fault counter. If errors become too dense, the analyzer drops lock and searches again. Software-side logic reads the counter and pulses a clear strobe. The slot code mapping and the two polynomials are the same as those of the matching pattern generator, so a looped-back stream counts no faults once locked.

Top module: `prbs_analyzer`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), `seq_recovered` is 0 and `fault_count` is 0.
- R2: Slot codes: 0 selects slots 1 to 31; 1 to 31 select only that slot; 32 selects all 32 slots; 33 to 63 select no slot. Bits outside the selected slots are neither compared nor loaded. No bits are taken before the first `fsync`, which is high in the first bit period of slot 0.
- R3: With `long_seq` = 0 the expected sequence obeys b(n) = b(n-9) xor b(n-5) (x^9+x^5+1). With `long_seq` = 1 it obeys b(n) = b(n-15) xor b(n-14) (x^15+x^14+1).
- R4: While searching, each selected bit is loaded into the history. `seq_recovered` rises after the edge that samples the 32nd consecutive selected bit equal to its prediction, and never earlier.
- R5: While recovered, each selected bit that differs from the prediction raises `fault_count` by exactly one, and a matching stream leaves it unchanged.
- R6: Compared bits are grouped into windows of 256, with the first window starting at lock. Up to 10 faults in a window keep lock. The 11th fault in a window is counted, clears `seq_recovered` and restarts the search. Faults seen while searching are not counted.
- R7: `fault_count` saturates at its all-ones value (16383 for 14 bits) and never wraps.
- R8: A one-cycle `cnt_clr` sets `fault_count` to 0 on the next edge. If it coincides with a counted fault, the count becomes 1.
- R9: With `ana_en` at 0, `seq_recovered` is 0 after the next edge, no bits are compared or loaded, the history is frozen, `fault_count` holds its value and `cnt_clr` still works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | Frame start, high during the first bit of slot 0 |
| rx_data | input | 1 | Received serial data |
| ana_en | input | 1 | Analyzer enable |
| slot_code | input | 6 | Timeslot selection code |
| long_seq | input | 1 | Sequence length select (0: 511, 1: 32767) |
| cnt_clr | input | 1 | Fault counter clear strobe |
| seq_recovered | output | 1 | Sequence recovered flag |
| fault_count | output | ERR_W (14) | Saturating fault count |

## Verification
A corrupted history register shows up as a burst of counted faults within 15 compared bits of the corruption. The burst then drops lock within a few dozen bits. A frame-position error moves the sampling into the wrong slot, so single-slot modes fail to lock and the flag stays low for whole frames. The bench disables and re-enables the analyzer while it holds a correct history. This fixes lock on an exact selected-bit index, so the window boundaries of R6 and the lock point of R4 are checked cycle-exactly. A miscounted window shows up as an early or late loss within one 256-bit window.

// File: rtl/prbsa_pkg.sv
`timescale 1ns/1ps
// Shared constants, types and helper functions for the timeslot PRBS analyzer.
// Assumes a frame of 32 slots of 8 bits and a history register wide enough
// for the longer polynomial.
package prbsa_pkg;
    localparam int SLOTS      = 32;
    localparam int SLOT_BITS  = 8;
    localparam int SLOT_W     = $clog2(SLOTS);
    localparam int HIST_W     = 15;
    localparam int CODE_W     = 6;

    localparam logic [CODE_W-1:0] SEL_ALL_BUT_0 = 6'd0;
    localparam logic [CODE_W-1:0] SEL_ALL       = 6'd32;

    typedef enum logic {ST_SEARCH = 1'b0, ST_LOCKED = 1'b1} sync_state_e;

    // Decode whether a slot takes part in the comparison for a given code.
    function automatic logic slot_selected(logic [CODE_W-1:0] code,
                                           logic [SLOT_W-1:0] slot);
        if (code == SEL_ALL_BUT_0)
            return slot != '0;
        else if (code == SEL_ALL)
            return 1'b1;
        else if (code < SEL_ALL)
            return code[SLOT_W-1:0] == slot;
        else
            return 1'b0;
    endfunction

    // Next sequence bit from the history (bit 0 is the newest bit).
    function automatic logic predict_bit(logic [HIST_W-1:0] hist, logic long_sel);
        if (long_sel)
            return hist[14] ^ hist[13];
        else
            return hist[8] ^ hist[4];
    endfunction
endpackage

// File: rtl/prbsa_slot_gate.sv
`timescale 1ns/1ps
// Frame position tracker and slot gate.
// Counts bit periods from the frame-sync pulse and flags the bits that
// belong to the slots chosen by the selection code. Assumes fsync marks the
// first bit of slot 0; no bit is flagged before the first fsync.
module prbsa_slot_gate
    import prbsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              en,
    input  logic [CODE_W-1:0] sel_code,
    output logic              bit_valid
);
    localparam int FRAME_BITS = SLOTS * SLOT_BITS;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int SB_W       = $clog2(SLOT_BITS);

    logic [POS_W-1:0]  pos_q;
    logic [POS_W-1:0]  pos_cur;
    logic              framed_q;
    logic              framed_cur;
    logic [SLOT_W-1:0] slot_cur;

    // Position of the bit present in this cycle.
    always_comb begin
        if (fsync)
            pos_cur = '0;
        else if (pos_q == POS_W'(FRAME_BITS - 1))
            pos_cur = '0;
        else
            pos_cur = pos_q + 1'b1;
        framed_cur = fsync | framed_q;
        slot_cur   = pos_cur[POS_W-1:SB_W];
        bit_valid  = en & framed_cur & slot_selected(sel_code, slot_cur);
    end

    // Hold the frame position and the seen-a-frame flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q    <= '1;
            framed_q <= 1'b0;
        end else begin
            pos_q    <= pos_cur;
            framed_q <= framed_cur;
        end
    end

    // R2
    reserved_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code > SEL_ALL) |-> !bit_valid);

    // R9
    dis_no_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !bit_valid);
endmodule

// File: rtl/prbsa_lfsr.sv
`timescale 1ns/1ps
// History register and predictor.
// On every selected bit it shifts in either the received bit (while
// searching) or its own prediction (while locked). Assumes the caller
// steps it only on selected bits.
module prbsa_lfsr
    import prbsa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic load_rx,
    input  logic rx_bit,
    input  logic long_sel,
    output logic predicted
);
    logic [HIST_W-1:0] hist_q;

    // Prediction for the current selected bit.
    always_comb predicted = predict_bit(hist_q, long_sel);

    // Advance the history on each selected bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist_q <= '0;
        else if (step)
            hist_q <= {hist_q[HIST_W-2:0], load_rx ? rx_bit : predicted};
    end

    // R9
    hist_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(hist_q));
endmodule

// File: rtl/prbsa_sync.sv
`timescale 1ns/1ps
// Lock and loss state machine.
// Searches for LOCK_MATCHES matching bits in a row, then tracks fault
// density in windows of WINDOW_BITS compared bits. It drops lock on fault
// number LOSS_LIMIT+1 within one window. Assumes bit_valid is already
// gated by enable.
module prbsa_sync
    import prbsa_pkg::*;
#(
    parameter int LOCK_MATCHES = 32,
    parameter int WINDOW_BITS  = 256,
    parameter int LOSS_LIMIT   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bit_valid,
    input  logic mismatch,
    output logic locked,
    output logic load_rx,
    output logic count_fault
);
    localparam int MATCH_W = $clog2(LOCK_MATCHES);
    localparam int WIN_W   = $clog2(WINDOW_BITS);
    localparam int WERR_W  = $clog2(LOSS_LIMIT + 1);

    sync_state_e       state_q;
    logic [MATCH_W-1:0] match_q;
    logic [WIN_W-1:0]   win_pos_q;
    logic [WERR_W-1:0]  win_err_q;
    logic               loss_now;

    // Decode state outputs and the fault that breaks lock.
    always_comb begin
        locked      = (state_q == ST_LOCKED);
        load_rx     = !locked;
        count_fault = locked & bit_valid & mismatch;
        loss_now    = count_fault & (win_err_q == WERR_W'(LOSS_LIMIT));
    end

    // Search, lock and window bookkeeping per selected bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state_q   <= ST_SEARCH;
            match_q   <= '0;
            win_pos_q <= '0;
            win_err_q <= '0;
        end else if (bit_valid) begin
            case (state_q)
                ST_SEARCH: begin
                    if (mismatch) begin
                        match_q <= '0;
                    end else if (match_q == MATCH_W'(LOCK_MATCHES - 1)) begin
                        state_q   <= ST_LOCKED;
                        match_q   <= '0;
                        win_pos_q <= '0;
                        win_err_q <= '0;
                    end else begin
                        match_q <= match_q + 1'b1;
                    end
                end
                default: begin
                    if (loss_now) begin
                        state_q <= ST_SEARCH;
                        match_q <= '0;
                    end else if (win_pos_q == WIN_W'(WINDOW_BITS - 1)) begin
                        win_pos_q <= '0;
                        win_err_q <= '0;
                    end else begin
                        win_pos_q <= win_pos_q + 1'b1;
                        if (mismatch)
                            win_err_q <= win_err_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // R9
    dis_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !locked);

    // R4
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(bit_valid && !mismatch));

    // R6
    loss_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_fault && win_err_q == WERR_W'(LOSS_LIMIT)) |=> !locked);
endmodule

// File: rtl/prbsa_err_ctr.sv
`timescale 1ns/1ps
// Saturating fault counter with clear strobe.
// A fault arriving together with the clear is kept as a count of one.
module prbsa_err_ctr #(
    parameter int ERR_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [ERR_W-1:0] count
);
    localparam logic [ERR_W-1:0] CNT_MAX = '1;

    // Clear, count up, or hold at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= ERR_W'(inc);
        else if (inc && count != CNT_MAX)
            count <= count + 1'b1;
    end

    // R7
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX && !clr) |=> count == CNT_MAX);

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !inc) |=> count == '0);

    // R5
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && count != CNT_MAX) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/prbs_analyzer.sv
`timescale 1ns/1ps
// Timeslot PRBS analyzer top.
// Gates the serial stream down to the selected slots, predicts each bit
// from a local history, locks and unlocks on fault density, and counts
// faults while locked. Assumes rx_data and fsync are aligned to clk.
module prbs_analyzer
    import prbsa_pkg::*;
#(
    parameter int ERR_W        = 14,
    parameter int LOCK_MATCHES = 32,
    parameter int WINDOW_BITS  = 256,
    parameter int LOSS_LIMIT   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  logic             rx_data,
    input  logic             ana_en,
    input  logic [5:0]       slot_code,
    input  logic             long_seq,
    input  logic             cnt_clr,
    output logic             seq_recovered,
    output logic [ERR_W-1:0] fault_count
);
    logic bit_valid;
    logic predicted;
    logic mismatch;
    logic load_rx;
    logic count_fault;

    prbsa_slot_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .en        (ana_en),
        .sel_code  (slot_code),
        .bit_valid (bit_valid)
    );

    prbsa_lfsr u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (bit_valid),
        .load_rx   (load_rx),
        .rx_bit    (rx_data),
        .long_sel  (long_seq),
        .predicted (predicted)
    );

    // Compare the received bit with the local prediction.
    always_comb mismatch = rx_data ^ predicted;

    prbsa_sync #(
        .LOCK_MATCHES (LOCK_MATCHES),
        .WINDOW_BITS  (WINDOW_BITS),
        .LOSS_LIMIT   (LOSS_LIMIT)
    ) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (ana_en),
        .bit_valid   (bit_valid),
        .mismatch    (mismatch),
        .locked      (seq_recovered),
        .load_rx     (load_rx),
        .count_fault (count_fault)
    );

    prbsa_err_ctr #(
        .ERR_W (ERR_W)
    ) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (count_fault),
        .clr   (cnt_clr),
        .count (fault_count)
    );
endmodule

// File: tb/prbs_analyzer_tb.sv
`timescale 1ns/1ps
module prbs_analyzer_tb;
    localparam int SAT_W = 6;

    logic clk = 1'b0, rst_n = 1'b0, fsync = 1'b0, rx_data = 1'b0;
    logic ana_en = 1'b0, long_seq = 1'b0, cnt_clr = 1'b0;
    logic [5:0] slot_code = '0;
    logic seq_recovered, sat_recovered;
    logic [13:0] fault_count;
    logic [SAT_W-1:0] sat_count;

    always #2 clk = ~clk;

    prbs_analyzer u_dut (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .rx_data(rx_data),
        .ana_en(ana_en), .slot_code(slot_code), .long_seq(long_seq),
        .cnt_clr(cnt_clr), .seq_recovered(seq_recovered), .fault_count(fault_count));

    prbs_analyzer #(.ERR_W(SAT_W)) u_sat (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .rx_data(rx_data),
        .ana_en(ana_en), .slot_code(slot_code), .long_seq(long_seq),
        .cnt_clr(cnt_clr), .seq_recovered(sat_recovered), .fault_count(sat_count));

    typedef struct { string tag; bit rec; int cnt; bit sat; } exp_t;
    exp_t sb_q[$];
    int checks = 0, errors = 0;
    bit done = 0;

    // stimulus state
    bit want_en = 1, want_long = 1, clr_pending = 0;
    logic [5:0] want_code = 6'd0;
    int frame_pos = 0, sel_idx = 0, inv_n = 0;
    int per = 0, ph = 0, inv_lo = -1, inv_hi = -1, clr_at = -1;
    logic [14:0] gen = '1;
    logic [15:0] junk = 16'hACE1;
    int exp_cnt = 0;

    function automatic bit bench_sel(logic [5:0] c, int slot);
        if (c == 6'd0)  return slot != 0;
        if (c == 6'd32) return 1'b1;
        if (c <= 6'd31) return slot == int'(c);
        return 1'b0;
    endfunction

    // one bit period of stimulus
    task automatic step();
        int slot;
        bit sel, inv;
        logic nb;
        @(negedge clk);
        ana_en = want_en; slot_code = want_code; long_seq = want_long;
        fsync = (frame_pos == 0);
        slot = frame_pos / 8;
        sel = want_en && bench_sel(want_code, slot);
        cnt_clr = clr_pending; clr_pending = 0;
        if (sel) begin
            nb = want_long ? (gen[14] ^ gen[13]) : (gen[8] ^ gen[4]);
            gen = {gen[13:0], nb};
            inv = (per > 0 && (sel_idx % per) == ph) || (sel_idx >= inv_lo && sel_idx <= inv_hi);
            if (inv) inv_n++;
            rx_data = nb ^ inv;
            if (sel_idx == clr_at) cnt_clr = 1'b1;
            sel_idx++;
        end else begin
            junk = {junk[14:0], junk[15] ^ junk[13] ^ junk[12] ^ junk[10]};
            rx_data = junk[0];
        end
        frame_pos = (frame_pos + 1) % 256;
    endtask

    task automatic drive(int n);
        for (int i = 0; i < n; i++) step();
        #1;
    endtask

    task automatic drive_sel(int n);
        int target;
        target = sel_idx + n;
        while (sel_idx < target) step();
        #1;
    endtask

    task automatic expect_out(string tag, bit rec, int cnt);
        exp_t e;
        e.tag = tag; e.rec = rec; e.cnt = cnt; e.sat = 0;
        sb_q.push_back(e);
    endtask

    task automatic expect_sat(string tag, bit rec, int cnt);
        exp_t e;
        e.tag = tag; e.rec = rec; e.cnt = cnt; e.sat = 1;
        sb_q.push_back(e);
    endtask

    // monitor: compares queued expectations once the outputs have settled
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t e;
                bit ar;
                int ac;
                e = sb_q.pop_front();
                ar = e.sat ? sat_recovered : seq_recovered;
                ac = e.sat ? int'(sat_count) : int'(fault_count);
                checks++;
                if (ar !== e.rec || ac != e.cnt) begin
                    errors++;
                    $display("FAIL %s: actual rec=%0b cnt=%0d expected rec=%0b cnt=%0d",
                             e.tag, ar, ac, e.rec, e.cnt);
                end
            end
        end
    end

    task automatic pause_and_switch(logic [5:0] code, bit lng);
        want_en = 0;
        drive(4);
        want_code = code; want_long = lng; gen = '1;
        want_en = 1;
    endtask

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        expect_out("R1 reset state", 0, 0);

        // R4: too few selected bits to lock
        drive(20);
        expect_out("R4 no early lock", 0, 0);

        // R3 R5: long sequence, slots 1..31, clean
        drive(512);
        expect_out("R3 R5 lock clean long", 1, 0);

        // R5: sparse faults
        per = 100; ph = 7; inv_n = 0;
        drive(768);
        per = 0; exp_cnt += inv_n;
        expect_out("R5 sparse faults", 1, exp_cnt);

        // R8: clear
        clr_pending = 1; drive(4); exp_cnt = 0;
        expect_out("R8 clear", 1, 0);

        // R2: junk in slot 0 ignored
        drive(768);
        expect_out("R2 slot0 junk ignored", 1, 0);

        // R8: clear coincides with a fault
        clr_at = sel_idx + 5; inv_lo = clr_at; inv_hi = clr_at;
        drive(40);
        clr_at = -1; inv_lo = -1; inv_hi = -1; exp_cnt = 1;
        expect_out("R8 clear with fault", 1, 1);

        // R9: disable
        want_en = 0;
        drive(1);
        expect_out("R9 disable drops flag", 0, 1);
        drive(300);
        expect_out("R9 disabled holds count", 0, 1);
        clr_pending = 1; drive(2); exp_cnt = 0;
        expect_out("R9 clear while disabled", 0, 0);

        // R4 R6: deterministic lock from frozen history
        want_en = 1;
        base = sel_idx;
        drive_sel(31);
        expect_out("R4 no lock at 31 matches", 0, 0);
        drive_sel(1);
        expect_out("R4 lock at 32 matches", 1, 0);
        inv_lo = base + 32; inv_hi = base + 41;
        drive_sel(10);
        expect_out("R6 ten faults keep lock", 1, 10);
        inv_lo = base + 32 + 256; inv_hi = base + 32 + 265;
        drive_sel(256);
        expect_out("R6 window restart", 1, 20);
        inv_lo = -1; inv_hi = -1;

        // R6: loss on the 11th fault in a window
        want_en = 0; drive(4); want_en = 1;
        base = sel_idx;
        inv_lo = base + 32; inv_hi = base + 53;
        drive_sel(54);
        inv_lo = -1; inv_hi = -1; exp_cnt = 31;
        expect_out("R6 loss on 11th fault", 0, 31);
        drive(768);
        expect_out("R6 relock no search count", 1, 31);

        // R3 R2: short sequence in slot 5 only
        pause_and_switch(6'd5, 0);
        drive(256 * 8);
        expect_out("R3 R2 short seq slot5 lock", 1, exp_cnt);
        per = 20; ph = 3; inv_n = 0;
        drive(256 * 8);
        per = 0; exp_cnt += inv_n;
        expect_out("R5 slot5 faults", 1, exp_cnt);

        // R2: all slots including slot 0
        pause_and_switch(6'd32, 0);
        drive(256);
        expect_out("R2 all slots lock", 1, exp_cnt);

        // R2: reserved codes select nothing
        pause_and_switch(6'd33, 0);
        drive(1024);
        expect_out("R2 code33 no lock", 0, exp_cnt);
        pause_and_switch(6'd50, 1);
        drive(1024);
        expect_out("R2 code50 no lock", 0, exp_cnt);

        // R7: saturation on the narrow instance
        pause_and_switch(6'd32, 1);
        drive(256);
        per = 30; ph = 3; inv_n = 0; clr_pending = 1;
        drive(2100);
        per = 0;
        expect_out("R7 wide counter exact", 1, inv_n);
        expect_sat("R7 narrow counter saturates", 1, (inv_n > 63) ? 63 : inv_n);

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1..all: actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule